// File: doc/BRIEF.md
# Two-Wire Serial Slave Receiver with Software Acknowledge Control

This block is the receive side of a two-wire serial slave. It samples the clock and data lines with the system clock through a synchronizer and a glitch filter. It detects START, repeated START and STOP conditions and shifts in the address byte. It acknowledges either its own 7-bit address or, when enabled, the general call address. It then takes in data bytes and acknowledges each one according to a software-controlled acknowledge enable.

Software sees four byte-wide registers:

| Index | Register | Access | Contents |
|---|---|---|---|
| 0 | Address | read/write | own address in bits 7:1, general call enable in bit 0 |
| 1 | Control | read/write | enable in bit 0, acknowledge enable in bit 1, event flag in bit 7 |
| 2 | Status | read-only | code for the latest event |
| 3 | Data | read-only | last received byte |

Writing a one to the flag bit clears the flag. While the flag is set the block holds the clock line low, so the bus master waits until software has handled the byte.

Top module: `i2cSlaveRx`

## Requirements
- R1: After reset the status reads 0xF8, the flag and both line drives are 0, and the address, control and data registers read 0.
- R2: With the block enabled (control bit 0) and acknowledge enabled (control bit 1), an address byte whose bits 7:1 equal address register bits 7:1 and whose bit 0 is 0 is answered by pulling SDA low in the ninth clock. At the end of that clock the flag is set and the status becomes 0x60.
- R3: The address byte 0x00 is acknowledged with status 0x70 only when address register bit 0 is 1. When that bit is 0 it gets no acknowledge and no flag.
- R4: An address that matches neither its own nor a general call is not acknowledged. It does not change the flag, the status or the data register, and the data bytes that follow are ignored.
- R5: Data bytes are taken MSB first and placed in the data register. When acknowledged, the status becomes 0x80 after an own-address write or 0x90 after a general call.
- R6: A data byte that completes while the acknowledge enable is 0 is answered with NACK (SDA left high). Its status is 0x88 (own address) or 0x98 (general call), and later bytes are ignored until the next START.
- R7: While the acknowledge enable is 0, the own address gets no acknowledge. After the enable is set again, the address is recognized at the next START.
- R8: SCL is held low while the flag is set after an acknowledge or data phase. Writing the control register with bit 7 = 1 clears the flag, releases SCL and returns the status to 0xF8. A write with bit 7 = 0 leaves the flag set.
- R9: A STOP or repeated START while addressed sets the flag with status 0xA0 and does not hold SCL.
- R10: An own-address byte with bit 0 = 1 (read) is not acknowledged. It sets the flag with status 0xA8 and does not hold SCL.
- R11: With control bit 0 = 0 the block ignores the bus: no acknowledge and no flag.
- R12: A pulse on SCL shorter than the filter length is ignored and does not shift a bit.
- R13: The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sclDriveLow | output | 1 | 1 pulls the clock line low (clock stretching) |
| sdaDriveLow | output | 1 | 1 pulls the data line low (acknowledge) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index: 0 address, 1 control, 2 status, 3 data |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the indexed register |
| irq | output | 1 | Event flag |

## Verification
The hardest case to reach from the ports is a bus master that is actually stalled by the stretched clock. The bench master must wait on the wired-AND clock line instead of its own timing. The stimulus forks a master byte transfer against a software thread. That thread leaves the flag set, looks at the bus clock after several bit times, writes control with bit 7 clear, and only then clears the flag.

Two other stimuli also need care. An acknowledge-enable change is placed exactly between an acknowledged byte and the next one. A one-cycle low pulse is inserted on SCL during a high phase.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK
  } rxState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic shiftEn;
    logic cntClr;
    logic loadData;
  } dpCtl_t;

  // datapath -> control events and decodes
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic byteFull;
    logic ownWrite;
    logic ownRead;
    logic gcWrite;
  } dpEvt_t;

  localparam logic [7:0] CODE_OWN_ACK       = 8'h60;
  localparam logic [7:0] CODE_GC_ACK        = 8'h70;
  localparam logic [7:0] CODE_OWN_DATA_ACK  = 8'h80;
  localparam logic [7:0] CODE_OWN_DATA_NACK = 8'h88;
  localparam logic [7:0] CODE_GC_DATA_ACK   = 8'h90;
  localparam logic [7:0] CODE_GC_DATA_NACK  = 8'h98;
  localparam logic [7:0] CODE_END           = 8'hA0;
  localparam logic [7:0] CODE_READ_REQ      = 8'hA8;
  localparam logic [7:0] CODE_IDLE          = 8'hF8;

  localparam logic [1:0] REG_ADDR   = 2'd0;
  localparam logic [1:0] REG_CTRL   = 2'd1;
  localparam logic [1:0] REG_STATUS = 2'd2;
  localparam logic [1:0] REG_DATA   = 2'd3;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_ACK_BIT  = 1;
  localparam int CTRL_FLAG_BIT = 7;

endpackage

// File: rtl/i2cRxDatapath.sv
module i2cRxDatapath
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int BYTE_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 addrWrEn,
  input  logic [BYTE_BITS-1:0] addrWrData,
  input  dpCtl_t               ctl,
  output dpEvt_t               evt,
  output logic [BYTE_BITS-1:0] addrRegOut,
  output logic [BYTE_BITS-1:0] dataRegOut
);

  localparam int FCNT_W = $clog2(FILT_LEN + 1);
  localparam int BCNT_W = $clog2(BYTE_BITS + 1);

  logic [1:0] rawLine;
  logic [1:0] filtLine;
  logic [1:0] filtPrev;

  assign rawLine = {sdaIn, sclIn};

  // per-line synchronizer and glitch filter
  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [SYNC_STAGES-1:0] syncChain;
    logic [FCNT_W-1:0]      stableCnt;
    logic                   filtBit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain <= '1;
        stableCnt <= '0;
        filtBit   <= 1'b1;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], rawLine[g]};
        if (syncChain[SYNC_STAGES-1] == filtBit) begin
          stableCnt <= '0;
        end else if (stableCnt == FCNT_W'(FILT_LEN - 1)) begin
          filtBit   <= syncChain[SYNC_STAGES-1];
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end
    end

    assign filtLine[g] = filtBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) filtPrev <= '1;
    else       filtPrev <= filtLine;
  end

  logic sclF, sdaF;
  assign sclF = filtLine[0];
  assign sdaF = filtLine[1];

  logic [BYTE_BITS-1:0] shiftReg;
  logic [BCNT_W-1:0]    bitCnt;
  logic [BYTE_BITS-1:0] addrReg;
  logic [BYTE_BITS-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctl.cntClr) begin
      bitCnt   <= '0;
    end else if (ctl.shiftEn) begin
      shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaF};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (addrWrEn)     addrReg <= addrWrData;
      if (ctl.loadData) dataReg <= shiftReg;
    end
  end

  always_comb begin
    evt.sclRise   = sclF & ~filtPrev[0];
    evt.sclFall   = ~sclF & filtPrev[0];
    evt.startSeen = sclF & filtPrev[0] & ~sdaF & filtPrev[1];
    evt.stopSeen  = sclF & filtPrev[0] & sdaF & ~filtPrev[1];
    evt.byteFull  = (bitCnt == BCNT_W'(BYTE_BITS));
    evt.ownWrite  = (shiftReg[BYTE_BITS-1:1] == addrReg[BYTE_BITS-1:1]) & ~shiftReg[0];
    evt.ownRead   = (shiftReg[BYTE_BITS-1:1] == addrReg[BYTE_BITS-1:1]) & shiftReg[0];
    evt.gcWrite   = (shiftReg == '0) & addrReg[0];
  end

  assign addrRegOut = addrReg;
  assign dataRegOut = dataReg;

endmodule

// File: rtl/i2cRxControl.sv
module i2cRxControl
  import i2c_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic [7:0] ctrlWrData,
  input  dpEvt_t     evt,
  output dpCtl_t     ctl,
  output logic       sdaDriveLow,
  output logic       sclDriveLow,
  output logic       flag,
  output logic [7:0] ctrlRegOut,
  output logic [7:0] statusOut
);

  rxState_e   state;
  logic       enable, ackEn, hold, sdaLow, isGc, ackGiven;
  logic [7:0] status;
  logic       addressed;

  assign addressed = (state == ST_ADDR_ACK) || (state == ST_DATA) || (state == ST_DATA_ACK);

  always_comb begin
    ctl.shiftEn  = enable && evt.sclRise && !evt.byteFull &&
                   ((state == ST_ADDR) || (state == ST_DATA));
    ctl.cntClr   = enable && (evt.startSeen ||
                   (evt.sclFall && ((state == ST_ADDR_ACK) || (state == ST_DATA_ACK))));
    ctl.loadData = enable && (state == ST_DATA) && evt.sclFall && evt.byteFull &&
                   !evt.startSeen && !evt.stopSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      enable   <= 1'b0;
      ackEn    <= 1'b0;
      flag     <= 1'b0;
      hold     <= 1'b0;
      sdaLow   <= 1'b0;
      isGc     <= 1'b0;
      ackGiven <= 1'b0;
      status   <= CODE_IDLE;
    end else begin
      // software side: clear first, bus events below override a clear
      if (ctrlWrEn) begin
        enable <= ctrlWrData[CTRL_EN_BIT];
        ackEn  <= ctrlWrData[CTRL_ACK_BIT];
        if (ctrlWrData[CTRL_FLAG_BIT]) begin
          flag   <= 1'b0;
          hold   <= 1'b0;
          status <= CODE_IDLE;
        end
      end

      if (!enable) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
      end else if (evt.stopSeen || evt.startSeen) begin
        sdaLow <= 1'b0;
        if (addressed) begin
          flag   <= 1'b1;
          hold   <= 1'b0;
          status <= CODE_END;
        end
        state <= evt.startSeen ? ST_ADDR : ST_IDLE;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (evt.sclFall && evt.byteFull) begin
              if (ackEn && evt.ownWrite) begin
                sdaLow <= 1'b1;
                isGc   <= 1'b0;
                state  <= ST_ADDR_ACK;
              end else if (ackEn && evt.gcWrite) begin
                sdaLow <= 1'b1;
                isGc   <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else if (evt.ownRead) begin
                flag   <= 1'b1;
                hold   <= 1'b0;
                status <= CODE_READ_REQ;
                state  <= ST_IDLE;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (evt.sclFall) begin
              sdaLow <= 1'b0;
              flag   <= 1'b1;
              hold   <= 1'b1;
              status <= isGc ? CODE_GC_ACK : CODE_OWN_ACK;
              state  <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (evt.sclFall && evt.byteFull) begin
              sdaLow   <= ackEn;
              ackGiven <= ackEn;
              state    <= ST_DATA_ACK;
            end
          end
          ST_DATA_ACK: begin
            if (evt.sclFall) begin
              sdaLow <= 1'b0;
              flag   <= 1'b1;
              hold   <= 1'b1;
              if (isGc) status <= ackGiven ? CODE_GC_DATA_ACK : CODE_GC_DATA_NACK;
              else      status <= ackGiven ? CODE_OWN_DATA_ACK : CODE_OWN_DATA_NACK;
              state  <= ackGiven ? ST_DATA : ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDriveLow = sdaLow;
  assign sclDriveLow = flag & hold;
  assign statusOut   = status;

  always_comb begin
    ctrlRegOut                = '0;
    ctrlRegOut[CTRL_EN_BIT]   = enable;
    ctrlRegOut[CTRL_ACK_BIT]  = ackEn;
    ctrlRegOut[CTRL_FLAG_BIT] = flag;
  end

endmodule

// File: rtl/i2cSlaveRx.sv
module i2cSlaveRx
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irq
);

  dpCtl_t     ctl;
  dpEvt_t     evt;
  logic [7:0] addrRegVal, dataRegVal, ctrlRegVal, statusVal;

  i2cRxDatapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN),
    .BYTE_BITS  (8)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .addrWrEn  (regWrEn && (regAddr == REG_ADDR)),
    .addrWrData(regWrData),
    .ctl       (ctl),
    .evt       (evt),
    .addrRegOut(addrRegVal),
    .dataRegOut(dataRegVal)
  );

  i2cRxControl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (regWrEn && (regAddr == REG_CTRL)),
    .ctrlWrData (regWrData),
    .evt        (evt),
    .ctl        (ctl),
    .sdaDriveLow(sdaDriveLow),
    .sclDriveLow(sclDriveLow),
    .flag       (irq),
    .ctrlRegOut (ctrlRegVal),
    .statusOut  (statusVal)
  );

  always_comb begin
    unique case (regAddr)
      REG_ADDR:   regRdData = addrRegVal;
      REG_CTRL:   regRdData = ctrlRegVal;
      REG_STATUS: regRdData = statusVal;
      default:    regRdData = dataRegVal;
    endcase
  end

endmodule

// File: rtl/i2cSlaveRxChecker.sv
module i2cSlaveRxChecker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaDriveLow,
  input logic       sclDriveLow,
  input logic       irq,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData
);

  // R8: clock stretching only happens with the flag raised
  a_r8_hold_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow |-> irq);

  // R8: a flag-clearing control write releases the clock line
  a_r8_clear_releases: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && regWrData[7]) |=> !sclDriveLow);

  // R8: with no flag pending the status register shows the idle code
  a_r8_idle_code: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && regAddr == 2'd2) |-> regRdData == 8'hF8);

  // R13: the acknowledge drive moves only while the clock line is low
  a_r13_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);

  // R2: the acknowledge drive and the stretch never overlap
  a_r2_ack_not_stretched: assert property (@(posedge clk) disable iff (!rstN)
    !(sdaDriveLow && sclDriveLow));

endmodule

bind i2cSlaveRx i2cSlaveRxChecker u_chk (.*);

// File: tb/i2cSlaveRx_bench.sv
module i2cSlaveRx_bench;

  localparam int Q = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mSclLow = 1'b0, mSdaLow = 1'b0, glitchPulse = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sclDriveLow, sdaDriveLow, irq;
  logic       sclBus, sdaBus, sclIn;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  assign sclBus = !(mSclLow || sclDriveLow);
  assign sdaBus = !(mSdaLow || sdaDriveLow);
  assign sclIn  = sclBus && !glitchPulse;

  i2cSlaveRx u_i2cSlaveRx (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaBus),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  // behavioural reference model state
  int mOwn = 0, mGcEn = 0, mEn = 0, mAckEn = 0, mAddressed = 0, mIsGc = 0;
  int expFlag = 0, expStatus = 8'hF8, expData = 0, expHold = 0, expAck = 0;
  int dataQ[$];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setAddr(input logic [7:0] d);
    wrReg(2'd0, d);
    mOwn = d[7:1]; mGcEn = d[0];
  endtask

  task automatic setCtrl(input logic [7:0] d);
    wrReg(2'd1, d);
    mEn = d[0]; mAckEn = d[1];
    if (d[7]) begin expFlag = 0; expHold = 0; expStatus = 8'hF8; end
  endtask

  // model updates
  task automatic modelAddr(input logic [7:0] v);
    expAck = 0;
    if (!mEn) begin mAddressed = 0; return; end
    if (v[7:1] == mOwn[6:0] && !v[0] && mAckEn != 0) begin
      expAck = 1; expFlag = 1; expHold = 1; expStatus = 8'h60; mAddressed = 1; mIsGc = 0;
    end else if (v == 8'h00 && mGcEn != 0 && mAckEn != 0) begin
      expAck = 1; expFlag = 1; expHold = 1; expStatus = 8'h70; mAddressed = 1; mIsGc = 1;
    end else if (v[7:1] == mOwn[6:0] && v[0]) begin
      expFlag = 1; expHold = 0; expStatus = 8'hA8; mAddressed = 0;
    end else begin
      mAddressed = 0;
    end
  endtask

  task automatic modelData(input logic [7:0] v);
    expAck = 0;
    if (!mEn || !mAddressed) return;
    dataQ.push_back(v);
    expData = dataQ.pop_front();
    expAck = mAckEn;
    expFlag = 1; expHold = 1;
    if (mIsGc != 0) expStatus = (mAckEn != 0) ? 8'h90 : 8'h98;
    else            expStatus = (mAckEn != 0) ? 8'h80 : 8'h88;
    if (mAckEn == 0) mAddressed = 0;
  endtask

  task automatic modelEnd();
    if (mEn != 0 && mAddressed != 0) begin
      expFlag = 1; expHold = 0; expStatus = 8'hA0;
    end
    mAddressed = 0;
  endtask

  // bus master
  task automatic busStart();
    mSdaLow = 1'b1; cyc(Q);
    mSclLow = 1'b1; cyc(Q);
  endtask

  task automatic busRestart();
    mSdaLow = 1'b0; cyc(Q);
    mSclLow = 1'b0; wait (sclBus === 1'b1); cyc(Q);
    mSdaLow = 1'b1; cyc(Q);
    mSclLow = 1'b1; cyc(Q);
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; cyc(Q);
    mSclLow = 1'b0; wait (sclBus === 1'b1); cyc(Q);
    mSdaLow = 1'b0; cyc(2 * Q);
  endtask

  task automatic clockBit(input logic b, input logic glitchIt, output logic seen);
    mSdaLow = !b; cyc(Q);
    mSclLow = 1'b0; wait (sclBus === 1'b1); cyc(Q / 2);
    if (glitchIt) begin glitchPulse = 1'b1; cyc(1); glitchPulse = 1'b0; end
    cyc(Q / 2);
    seen = sdaBus;
    mSclLow = 1'b1; cyc(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, input int glitchBit, output logic ackSeen);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], i == glitchBit, s);
    clockBit(1'b1, 1'b0, s);
    ackSeen = !s;
  endtask

  task automatic verify(input string tag);
    logic [7:0] st, dt;
    rdReg(2'd2, st);
    rdReg(2'd3, dt);
    check({tag, " flag"}, irq, expFlag);
    check({tag, " status"}, st, expStatus);
    check({tag, " data"}, dt, expData);
    check({tag, " stretch"}, sclDriveLow, expFlag != 0 && expHold != 0);
  endtask

  task automatic doAddr(input string tag, input logic [7:0] v);
    logic a;
    sendByte(v, -1, a);
    modelAddr(v);
    check({tag, " ack"}, a, expAck);
    verify(tag);
  endtask

  task automatic doData(input string tag, input logic [7:0] v, input int glitchBit);
    logic a;
    sendByte(v, glitchBit, a);
    modelData(v);
    check({tag, " ack"}, a, expAck);
    verify(tag);
  endtask

  initial begin
    logic [7:0] rv;
    logic       ackS;
    cyc(5);
    rstN = 1'b1;
    cyc(3);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 sda drive", sdaDriveLow, 0);
    check("R1 scl drive", sclDriveLow, 0);
    rdReg(2'd0, rv); check("R1 addr reg", rv, 0);
    rdReg(2'd1, rv); check("R1 ctrl reg", rv, 0);
    rdReg(2'd2, rv); check("R1 status", rv, 8'hF8);
    rdReg(2'd3, rv); check("R1 data", rv, 0);

    setAddr(8'h54);
    setCtrl(8'h03);
    rdReg(2'd1, rv); check("R2 ctrl readback", rv, 8'h03);

    // R2 own address write, R5 data, R12 glitch
    busStart();
    doAddr("R2 own addr", 8'h54);
    setCtrl(8'h83); verify("R8 clear");
    doData("R5 data", 8'hA5, -1);
    setCtrl(8'h83);
    doData("R12 glitch data", 8'h3C, 3);
    // R8 stretch with a stalled master
    fork
      sendByte(8'h0F, -1, ackS);
      begin
        cyc(8 * Q);
        check("R8 scl held", sclBus, 0);
        setCtrl(8'h03);
        cyc(2 * Q);
        check("R8 flag kept", irq, 1);
        check("R8 still held", sclBus, 0);
        setCtrl(8'h83);
      end
    join
    modelData(8'h0F);
    check("R8 ack", ackS, expAck);
    verify("R8 resumed");

    // R6 NACK after acknowledge enable cleared
    setCtrl(8'h81);
    doData("R6 nack", 8'h77, -1);
    setCtrl(8'h81);
    doData("R6 ignored", 8'h11, -1);
    busStop(); modelEnd(); verify("R9 stop idle");

    // R7 ack disabled then re-enabled
    busStart();
    doAddr("R7 no ack", 8'h54);
    busStop(); modelEnd();
    setCtrl(8'h03);
    busStart();
    doAddr("R7 resumed", 8'h54);
    setCtrl(8'h83);
    doData("R5 data2", 8'h99, -1);
    setCtrl(8'h83);
    busRestart(); modelEnd(); verify("R9 restart");
    setCtrl(8'h83);
    doAddr("R10 read", 8'h55);
    setCtrl(8'h83);
    busStop(); modelEnd(); verify("R10 after stop");

    // R3 general call
    busStart();
    doAddr("R3 gc off", 8'h00);
    busStop(); modelEnd();
    setAddr(8'h55);
    busStart();
    doAddr("R3 gc on", 8'h00);
    setCtrl(8'h83);
    doData("R5 gc data", 8'hC3, -1);
    setCtrl(8'h81);
    doData("R6 gc nack", 8'h5A, -1);
    setCtrl(8'h83);
    busStop(); modelEnd(); verify("R6 gc idle");

    // R4 mismatched address
    busStart();
    doAddr("R4 mismatch", 8'h20);
    doData("R4 data ignored", 8'hFF, -1);
    busStop(); modelEnd(); verify("R4 stop");

    // R9 stop while addressed
    busStart();
    doAddr("R9 addr", 8'h54);
    setCtrl(8'h83);
    busStop(); modelEnd(); verify("R9 stop addressed");
    setCtrl(8'h83);

    // R11 disabled
    setCtrl(8'h02);
    busStart();
    doAddr("R11 disabled", 8'h54);
    busStop(); modelEnd(); verify("R11 stop");

    cyc(10);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule